// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the slave side of a four-wire serial link into the register file of a slow, high-resolution converter. The host drives chip select, a serial clock that idles high and a data input. The block answers on one output pin that has two jobs. While a word is being shifted out, the pin carries read data. At all other times it carries an active-low ready flag. The converter core hands over each finished result as a parallel word with a one-cycle load strobe. The block holds that result in a data register until the host fetches it.

Every access starts with one command byte. Its fields are: bit 7 must be 0 for the byte to count; bit 6 selects read (1) or write (0); bits 5:4 select the register; bit 2 asks for continuous reading. The four register addresses are: 0 is the command byte on writes and the status byte on reads, 1 is the 8-bit mode register, 2 is a fixed 8-bit identity byte, and 3 is the 24-bit result. In continuous reading, each new result is fetched by clocking alone, with no command byte in front of it.

The host may hold chip select low and use three wires, polling the ready bit in the status byte. It may instead pulse chip select as a frame marker, in which case the first data bit is on the pin before any clock edge. All serial inputs are synchronised to the system clock and then edge-detected.

Top module: `sdif_top`

## Requirements
- R1: After reset, the first 8 bits clocked in are a command byte. Any command byte with bit 7 = 1 is discarded, and the 8 bits after it are again taken as a command byte.
- R2: Command byte bit 6 = 1 means read and 0 means write. Bits 5:4 give the address: 0 = status, 1 = mode, 2 = identity, 3 = result. Bit 2 = 1 together with a read of address 3 asks for continuous reading.
- R3: A write command to address 1, followed by 8 data bits, loads the mode register; `mode_cfg` shows the new value. Data bits written to address 2 or 3 are dropped; the mode and identity values stay as they were.
- R4: Reads return 8 bits from addresses 0–2 and 24 bits from address 3, MSB first. Output bits change after a falling SCLK edge and input bits are taken at a rising edge.
- R5: When a result is loaded, the pin rises (not ready) in the cycle after the strobe and falls in the following cycle, which is the same cycle the data register takes the new value. The pin is therefore high before the data changes.
- R6: When a complete 24-bit result read finishes, the idle pin goes high and stays high until the next result arrives.
- R7: Outside continuous reading, the same result can be read again and again with the same value.
- R8: In continuous reading, a read starts at the first falling SCLK edge while the result is ready. Each result is delivered only once. SCLK pulses that arrive while the result is not ready shift out only the high idle level.
- R9: If, during a continuous read, the first 8 bits on DIN form a read command for address 3 with bit 2 = 0, continuous reading ends once that read completes. Normal command bytes are accepted again after that.
- R10: The status byte is {ready_n, 0, 0, 0, continuous, ID[2:0]}. With chip select held low the whole time, status polling and all other accesses work.
- R11: When a read is pending and chip select falls, the MSB of the word is on the pin before the first SCLK edge.
- R12: While chip select is high, `dout` is 1 and `dout_oe` is 0. Raising chip select part way through a byte or word aborts it and returns to waiting for a command byte. While chip select is low and no word is being shifted, `dout` shows the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data into the block |
| conv_word | input | DATA_W | New result from the converter core |
| conv_load | input | 1 | One-cycle strobe that loads `conv_word` |
| dout | output | 1 | Serial data out, or the ready flag when idle |
| dout_oe | output | 1 | High while the block drives the pin |
| mode_cfg | output | 8 | Current mode register value |

## Verification
The result path is driven with all-zero, all-one, alternating and arithmetic words. These expose dropped or swapped bits and shifts that are off by one position. The mode register is swept across spread-out byte values and each is read back, which separates a correct write from writes to read-only addresses and from discarded command bytes. Chip select is tested held low, pulsed as a frame marker, and raised mid-byte. These three cases separate correct MSB presentation, abort handling and 3-wire behaviour. Continuous reading is checked with a new result before each read, with clocking while no result is ready, and with an embedded exit command.

// File: rtl/sdif_pkg.sv
package sdif_pkg;

  typedef enum logic [2:0] {
    ST_CMD,   // waiting for command byte
    ST_WR,    // collecting write data
    ST_RD,    // shifting out a register
    ST_CRW,   // continuous read, waiting for ready
    ST_CRD    // continuous read, shifting out result
  } sdif_state_e;

  localparam logic [1:0] A_COMM = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_ID   = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  typedef struct packed {
    logic       wen_n;
    logic       rd;
    logic [1:0] addr;
    logic       rsv3;
    logic       cread;
    logic [1:0] rsv10;
  } comm_byte_t;

  localparam int unsigned BYTE_W = $bits(comm_byte_t);

endpackage

// File: rtl/sdif_sync.sv
module sdif_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_hi,
  output logic cs_fall,
  output logic din_s
);
  // bit order {sclk, cs_n, din}
  localparam logic [2:0] IDLE = 3'b110;

  logic [STAGES-1:0][2:0] chain_q;
  logic [2:0]             last_q;
  logic [2:0]             cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE}};
      last_q  <= IDLE;
    end else begin
      chain_q[0] <= {sclk, cs_n, din};
      for (int k = 1; k < int'(STAGES); k++) begin
        chain_q[k] <= chain_q[k-1];
      end
      last_q <= chain_q[STAGES-1];
    end
  end

  assign cur       = chain_q[STAGES-1];
  assign sclk_rise = cur[2] & ~last_q[2];
  assign sclk_fall = ~cur[2] & last_q[2];
  assign cs_hi     = cur[1];
  assign cs_fall   = ~cur[1] & last_q[1];
  assign din_s     = cur[0];

endmodule

// File: rtl/sdif_ready.sv
module sdif_ready #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] conv_word,
  input  logic              conv_load,
  input  logic              read_done,
  output logic [DATA_W-1:0] data_q,
  output logic              rdy_n
);
  logic [DATA_W-1:0] stage_q, stage_d, data_d;
  logic              pend_q, pend_d;
  logic              rdy_q, rdy_d;

  always_comb begin
    stage_d = stage_q;
    data_d  = data_q;
    pend_d  = pend_q;
    rdy_d   = rdy_q;
    if (conv_load) begin
      stage_d = conv_word;
      pend_d  = 1'b1;
      rdy_d   = 1'b1;
    end else if (pend_q) begin
      data_d  = stage_q;
      pend_d  = 1'b0;
      rdy_d   = 1'b0;
    end else if (read_done) begin
      rdy_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      data_q  <= '0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b1;
    end else begin
      stage_q <= stage_d;
      data_q  <= data_d;
      pend_q  <= pend_d;
      rdy_q   <= rdy_d;
    end
  end

  assign rdy_n = rdy_q;

  // R5
  upd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(rdy_q));

  // R6
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !conv_load && !pend_q) |=> rdy_q);

endmodule

// File: rtl/sdif_serial.sv
module sdif_serial
  import sdif_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter logic [7:0]  MODE_RST = 8'h02,
  parameter logic [7:0]  ID_VAL   = 8'h4B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_hi,
  input  logic              cs_fall,
  input  logic              din_s,
  input  logic              rdy_n,
  input  logic [DATA_W-1:0] data_q,
  output logic              read_done,
  output logic [7:0]        mode_cfg,
  output logic              dout,
  output logic              dout_oe
);
  localparam int unsigned    CNT_W   = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LEN_REG = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LEN_DAT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_B  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  sdif_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, len_q, len_d;
  logic [7:0]        sin_q, sin_d, mode_q, mode_d;
  logic [DATA_W-1:0] sout_q, sout_d;
  logic [1:0]        addr_q, addr_d;
  logic              cread_q, cread_d, exit_q, exit_d, done_q, done_d;
  comm_byte_t        cb;

  assign cb = comm_byte_t'({sin_q[6:0], din_s});

  function automatic logic [DATA_W-1:0] pick(input logic [1:0] a);
    logic [7:0] b;
    b = {rdy_n, 3'b000, cread_q, ID_VAL[2:0]};
    case (a)
      A_DATA: return data_q;
      A_MODE: b = mode_q;
      A_ID:   b = ID_VAL;
      default: ;
    endcase
    return {b, {(DATA_W-8){1'b0}}};
  endfunction

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    sin_d   = sin_q;
    mode_d  = mode_q;
    sout_d  = sout_q;
    addr_d  = addr_q;
    cread_d = cread_q;
    exit_d  = exit_q;
    done_d  = 1'b0;
    if (cs_hi) begin
      if (cnt_q != '0 || state_q == ST_CRD) begin
        cnt_d   = '0;
        exit_d  = 1'b0;
        state_d = (state_q == ST_CRD || state_q == ST_CRW) ? ST_CRW : ST_CMD;
      end
    end else begin
      case (state_q)
        ST_CMD: if (sclk_rise) begin
          sin_d = cb;
          cnt_d = cnt_q + ONE;
          if (cnt_q == LAST_B) begin
            cnt_d = '0;
            if (!cb.wen_n) begin
              if (cb.rd) begin
                if (cb.addr == A_DATA && cb.cread) begin
                  cread_d = 1'b1;
                  state_d = ST_CRW;
                end else begin
                  addr_d  = cb.addr;
                  len_d   = (cb.addr == A_DATA) ? LEN_DAT : LEN_REG;
                  sout_d  = pick(cb.addr);
                  state_d = ST_RD;
                end
              end else if (cb.addr != A_COMM) begin
                addr_d  = cb.addr;
                state_d = ST_WR;
              end
            end
          end
        end
        ST_WR: if (sclk_rise) begin
          sin_d = cb;
          cnt_d = cnt_q + ONE;
          if (cnt_q == LAST_B) begin
            cnt_d = '0;
            if (addr_q == A_MODE) mode_d = cb;
            state_d = ST_CMD;
          end
        end
        ST_RD: begin
          if (cs_fall && cnt_q == '0) begin
            sout_d = pick(addr_q);
          end else if (sclk_fall && cnt_q != '0) begin
            sout_d = sout_q << 1;
          end
          if (sclk_rise) begin
            cnt_d = cnt_q + ONE;
            if (cnt_q == len_q - ONE) begin
              cnt_d   = '0;
              done_d  = (addr_q == A_DATA);
              state_d = ST_CMD;
            end
          end
        end
        ST_CRW: if (sclk_fall && !rdy_n) begin
          sout_d  = data_q;
          cnt_d   = '0;
          state_d = ST_CRD;
        end
        ST_CRD: begin
          if (sclk_fall && cnt_q != '0) sout_d = sout_q << 1;
          if (sclk_rise) begin
            sin_d = cb;
            cnt_d = cnt_q + ONE;
            if (cnt_q == LAST_B && !cb.wen_n && cb.rd &&
                cb.addr == A_DATA && !cb.cread) begin
              exit_d = 1'b1;
            end
            if (cnt_q == LEN_DAT - ONE) begin
              cnt_d   = '0;
              done_d  = 1'b1;
              exit_d  = 1'b0;
              cread_d = !exit_q;
              state_d = exit_q ? ST_CMD : ST_CRW;
            end
          end
        end
        default: state_d = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      len_q   <= LEN_REG;
      sin_q   <= '0;
      mode_q  <= MODE_RST;
      sout_q  <= '0;
      addr_q  <= A_COMM;
      cread_q <= 1'b0;
      exit_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      sin_q   <= sin_d;
      mode_q  <= mode_d;
      sout_q  <= sout_d;
      addr_q  <= addr_d;
      cread_q <= cread_d;
      exit_q  <= exit_d;
      done_q  <= done_d;
    end
  end

  logic shifting;
  assign shifting  = (state_q == ST_RD) || (state_q == ST_CRD);
  assign dout      = cs_hi ? 1'b1 : (shifting ? sout_q[DATA_W-1] : rdy_n);
  assign dout_oe   = !cs_hi;
  assign read_done = done_q;
  assign mode_cfg  = mode_q;

  // R12
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && state_q == ST_WR && cnt_q != '0) |=> state_q == ST_CMD);

  // R8
  cread_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRD || state_q == ST_CRW) |-> cread_q);

  // R4
  len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD) |-> (cnt_q < len_q));

endmodule

// File: rtl/sdif_top.sv
module sdif_top #(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  MODE_RST    = 8'h02,
  parameter logic [7:0]  ID_VAL      = 8'h4B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] conv_word,
  input  logic              conv_load,
  output logic              dout,
  output logic              dout_oe,
  output logic [7:0]        mode_cfg
);
  logic              sclk_rise, sclk_fall, cs_hi, cs_fall, din_s;
  logic              rdy_n, read_done;
  logic [DATA_W-1:0] data_q;

  sdif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .sclk, .cs_n, .din,
    .sclk_rise, .sclk_fall, .cs_hi, .cs_fall, .din_s
  );

  sdif_ready #(.DATA_W(DATA_W)) u_ready (
    .clk, .rst_n, .conv_word, .conv_load, .read_done,
    .data_q, .rdy_n
  );

  sdif_serial #(.DATA_W(DATA_W), .MODE_RST(MODE_RST), .ID_VAL(ID_VAL)) u_serial (
    .clk, .rst_n, .sclk_rise, .sclk_fall, .cs_hi, .cs_fall, .din_s,
    .rdy_n, .data_q, .read_done, .mode_cfg, .dout, .dout_oe
  );

endmodule

// File: tb/sdif_top_test.sv
module sdif_top_test;
  localparam int         H     = 10;
  localparam logic [7:0] ID    = 8'h4B;
  localparam logic [7:0] MRST  = 8'h02;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, din, conv_load;
  logic [23:0] conv_word;
  logic        dout, dout_oe;
  logic [7:0]  mode_cfg;
  int          nchk = 0, nerr = 0;
  logic [31:0] rx, junk;
  logic [23:0] w;
  logic [7:0]  last_mode;

  always #2 clk = ~clk;

  sdif_top uut (
    .clk, .rst_n, .cs_n, .sclk, .din, .conv_word, .conv_load,
    .dout, .dout_oe, .mode_cfg
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift(input logic [31:0] tx, input int n, output logic [31:0] r);
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; din = tx[i];
      tick(H);
      r[i] = dout;
      sclk = 1'b1;
      tick(H);
    end
    din = 1'b1;
  endtask

  task automatic rd(input logic [7:0] cmd, input int n, output logic [31:0] r);
    logic [31:0] t;
    shift({24'h0, cmd}, 8, t);
    shift(32'hFFFF_FFFF, n, r);
  endtask

  task automatic wr(input logic [7:0] cmd, input logic [7:0] v);
    logic [31:0] t;
    shift({24'h0, cmd}, 8, t);
    shift({24'h0, v}, 8, t);
  endtask

  task automatic conv(input logic [23:0] v);
    @(negedge clk); conv_word = v; conv_load = 1'b1;
    @(negedge clk); conv_load = 1'b0;
    tick(3);
  endtask

  function automatic logic [31:0] stat(input logic rn, input logic cr);
    return {24'h0, rn, 3'b000, cr, ID[2:0]};
  endfunction

  function automatic logic [23:0] w_of(input int i);
    case (i)
      0: return 24'h000000;
      1: return 24'hFFFFFF;
      2: return 24'hA5A5A5;
      3: return 24'h800001;
      default: return 24'(i * 24'h2B3C5D) ^ 24'h5A0F33;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b1;
    conv_load = 1'b0; conv_word = '0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R12 reset state with chip select high
    check("R12 dout idle cs high", {31'h0, dout}, 32'h1);
    check("R12 oe cs high", {31'h0, dout_oe}, 32'h0);
    check("R3 mode reset", {24'h0, mode_cfg}, {24'h0, MRST});
    cs_n = 1'b0; tick(H);
    check("R12 dout shows not-ready", {31'h0, dout}, 32'h1);
    // R1 first byte is command; R10 status, 3-wire
    rd(8'h40, 8, rx); check("R1 R10 status after reset", rx, stat(1'b1, 1'b0));
    rd(8'h60, 8, rx); check("R2 identity read", rx, {24'h0, ID});
    rd(8'h50, 8, rx); check("R2 mode read", rx, {24'h0, MRST});
    // R3 mode sweep
    for (int v = 0; v < 256; v += 37) begin
      wr(8'h10, 8'(v));
      check("R3 mode_cfg after write", {24'h0, mode_cfg}, 32'(v));
      rd(8'h50, 8, rx); check("R4 mode readback", rx, 32'(v));
    end
    last_mode = 8'd222;
    wr(8'h20, 8'h99);
    check("R3 write to identity dropped", {24'h0, mode_cfg}, {24'h0, last_mode});
    rd(8'h60, 8, rx); check("R3 identity unchanged", rx, {24'h0, ID});
    wr(8'h30, 8'h00);
    rd(8'h50, 8, rx); check("R3 write to result dropped", rx, {24'h0, last_mode});
    // R1 discarded command byte
    shift(32'hFF, 8, junk);
    rd(8'h50, 8, rx); check("R1 bit7 byte discarded", rx, {24'h0, last_mode});
    // result sweep
    for (int i = 0; i < 6; i++) begin
      w = w_of(i);
      conv(w);
      check("R5 ready low after load", {31'h0, dout}, 32'h0);
      rd(8'h40, 8, rx); check("R10 status ready", rx, stat(1'b0, 1'b0));
      rd(8'h70, 24, rx); check("R4 result read", rx, {8'h0, w});
      check("R6 ready high after read", {31'h0, dout}, 32'h1);
      rd(8'h70, 24, rx); check("R7 result re-read", rx, {8'h0, w});
      rd(8'h40, 8, rx); check("R10 status not ready", rx, stat(1'b1, 1'b0));
    end
    // R5 ordering around an update
    conv(24'h123456);
    @(negedge clk); conv_word = 24'h654321; conv_load = 1'b1;
    @(negedge clk); conv_load = 1'b0;
    check("R5 not ready before update", {31'h0, dout}, 32'h1);
    @(negedge clk);
    check("R5 ready with new word", {31'h0, dout}, 32'h0);
    rd(8'h70, 24, rx); check("R5 new word read", rx, 32'h654321);
    // R8 continuous reading
    shift(32'h74, 8, junk);
    for (int i = 2; i < 6; i++) begin
      w = w_of(i + 3);
      conv(w);
      shift(32'hFFFF_FFFF, 24, rx); check("R8 continuous read", rx, {8'h0, w});
      check("R8 ready high after read", {31'h0, dout}, 32'h1);
      shift(32'h0, 24, rx); check("R8 no second delivery", rx, 32'h00FF_FFFF);
    end
    // R9 exit
    w = 24'h3C00C3;
    conv(w);
    shift({8'h0, 8'h70, 16'hFFFF}, 24, rx); check("R9 read with exit command", rx, {8'h0, w});
    rd(8'h40, 8, rx); check("R9 R10 status after exit", rx, stat(1'b1, 1'b0));
    // R11 frame sync
    for (int i = 0; i < 2; i++) begin
      w = (i == 0) ? 24'h9ABCDE : 24'h2468AC;
      cs_n = 1'b1; tick(H);
      conv(w);
      cs_n = 1'b0; tick(H);
      shift(32'h70, 8, junk);
      cs_n = 1'b1; tick(H);
      check("R12 dout high cs high", {31'h0, dout}, 32'h1);
      check("R12 oe low cs high", {31'h0, dout_oe}, 32'h0);
      cs_n = 1'b0; tick(H);
      check("R11 MSB before first edge", {31'h0, dout}, {31'h0, w[23]});
      shift(32'hFFFF_FFFF, 24, rx); check("R11 framed read", rx, {8'h0, w});
    end
    // R12 abort mid-byte
    shift(32'h10, 8, junk);
    shift(32'hA, 4, junk);
    cs_n = 1'b1; tick(H);
    cs_n = 1'b0; tick(H);
    rd(8'h50, 8, rx); check("R12 aborted write", rx, {24'h0, last_mode});
    check("R12 mode_cfg after abort", {24'h0, mode_cfg}, {24'h0, last_mode});
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule